// File: doc/BRIEF.md
# EPROM Programming Pulse Sequencer

This block sits on the programmer side of a one-time-programmable code memory and drives its parallel programming interface. A caller presents an operation code and a one-cycle start strobe. The sequencer latches the operation and drives the four mode-select lines with that operation's pattern. It also holds the target's reset line high and its program-store enable line low.

For a program operation it first raises the high-voltage enable and waits a setup interval. It then emits a fixed burst of active-low programming strobes. Each strobe has a counted low time and a counted high recovery time. The sequencer drops the high voltage after the burst and raises `done` for one cycle.

Verify and read operations use no strobes and no high voltage. The data port is sampled a settle interval after the mode lines are applied. The sample is decoded into a captured byte, the three security status bits, or the clock-mode status bit.

Each timing interval is a clock-cycle count that the parameters set. By default the low time is derived as 100 µs and the minimum high time as 10 µs at the configured clock rate. The FSM states are IDLE, SETUP, STROBE_LO, STROBE_HI, SETTLE and FINISH. Its transitions are:
- IDLE→SETUP on start with a program opcode.
- IDLE→SETTLE on start with a read or verify opcode.
- SETUP→STROBE_LO when the setup count expires.
- STROBE_LO→STROBE_HI when the low count expires.
- STROBE_HI→STROBE_LO when the high count expires and strobes remain.
- STROBE_HI→FINISH after the last strobe.
- SETTLE→FINISH when the settle count expires, sampling `data_in` on that edge.
- FINISH→IDLE unconditionally.

Top module: `eprom_burst_sequencer`

## Requirements
- R1: While busy, `mode_sel[3:0]` carries the latched operation's pattern, and it is 0000 when idle. The opcodes and their patterns are:
  - 0 read signature: 0000
  - 1 program code: 1011
  - 2 verify code: 0011
  - 3 program encryption: 1010
  - 4 program security bit 1: 1111
  - 5 program security bit 2: 1100
  - 6 program security bit 3: 0101
  - 7 program 6-clock mode: 0010
  - 8 verify clock mode: 0110
  - 9 verify security bits: 0100
- R2: After reset and whenever idle, the outputs are as follows: `busy`=0, `done`=0, `prog_n`=1, `vpp_en`=0, `tgt_rst`=0 and `tgt_psen_n`=1. The captured outputs are 0 after reset. While busy, `tgt_rst`=1 and `tgt_psen_n`=0.
- R3: A program operation (opcodes 1, 3, 4, 5, 6, 7) emits exactly PULSES strobes (default 5). Each strobe holds `prog_n` low for LOW_CYC cycles.
- R4: After each strobe, `prog_n` stays high for HIGH_CYC cycles before the next strobe or before `done`.
- R5: `vpp_en` rises in the first busy cycle of a program operation. It stays high until the last high interval ends and drops in the `done` cycle. `prog_n` is never low without `vpp_en`.
- R6: In a program operation, the first strobe falls SETUP_CYC cycles after `busy` rises.
- R7: Read and verify operations (opcodes 0, 2, 8, 9) keep `prog_n`=1 and `vpp_en`=0. They last SETTLE_CYC busy cycles followed by the `done` cycle.
- R8: Opcodes 0 and 2 load `cap_data` with `data_in` as sampled on the last settle cycle.
- R9: Opcode 9 loads `sec_bits[0]` from `data_in[7]`, `sec_bits[1]` from `data_in[6]` and `sec_bits[2]` from `data_in[3]`.
- R10: Opcode 8 loads `clk12_mode` from `data_in[4]`, where 1 means 12-clock and 0 means 6-clock. Other operations leave all captured outputs unchanged.
- R11: A start during busy has no effect on mode lines, strobes or the timing of `done`.
- R12: A start with an opcode of 10 to 15 is ignored, and `busy` stays low.
- R13: `done` is high for exactly one cycle. For program operations that cycle is the one right after the last high interval. `busy` is also high in that cycle and low in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Requested operation |
| start | input | 1 | One-cycle request strobe |
| data_in | input | 8 | Data port read back from the target |
| mode_sel | output | 4 | Mode-select lines to the target |
| tgt_rst | output | 1 | Target reset line, high during an operation |
| tgt_psen_n | output | 1 | Target program-store enable, low during an operation |
| prog_n | output | 1 | Active-low programming strobe |
| vpp_en | output | 1 | High-voltage enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cap_data | output | 8 | Byte captured by read signature or verify code |
| sec_bits | output | 3 | Security bits 1..3 captured by verify security |
| clk12_mode | output | 1 | Clock-mode bit captured by verify clock mode |

## Verification
The hardest situation to reach from the ports is a start that arrives in the middle of a burst. It has to land during a strobe's low phase, or on the very last high cycle, where a faulty FSM would restart or re-latch the mode. The bench predicts every output for every cycle of each operation from the requirement arithmetic. It injects a second start with a different opcode at chosen cycle offsets inside program and verify runs, and confirms that the mode lines, the strobe train and the `done` cycle are undisturbed. All sixteen opcodes are swept against several data patterns, so each capture field sees both polarities.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        OP_READ_SIG    = 4'd0,
        OP_PROG_CODE   = 4'd1,
        OP_VERIFY_CODE = 4'd2,
        OP_PROG_ENC    = 4'd3,
        OP_PROG_SEC1   = 4'd4,
        OP_PROG_SEC2   = 4'd5,
        OP_PROG_SEC3   = 4'd6,
        OP_PROG_CLK6   = 4'd7,
        OP_VERIFY_CLK  = 4'd8,
        OP_VERIFY_SEC  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_BYTE,
        CAP_SEC,
        CAP_CLK
    } cap_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_STROBE_LO,
        S_STROBE_HI,
        S_SETTLE,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/eprom_seq_decode.sv
module eprom_seq_decode
    import eprom_seq_pkg::*;
(
    input  logic [3:0] op,
    output logic       valid,
    output logic       is_prog,
    output logic [3:0] pattern,
    output cap_kind_e  kind
);
    always_comb begin
        valid   = 1'b1;
        is_prog = 1'b0;
        pattern = 4'b0000;
        kind    = CAP_NONE;
        unique case (op)
            OP_READ_SIG:    begin pattern = 4'b0000; kind = CAP_BYTE; end
            OP_PROG_CODE:   begin pattern = 4'b1011; is_prog = 1'b1; end
            OP_VERIFY_CODE: begin pattern = 4'b0011; kind = CAP_BYTE; end
            OP_PROG_ENC:    begin pattern = 4'b1010; is_prog = 1'b1; end
            OP_PROG_SEC1:   begin pattern = 4'b1111; is_prog = 1'b1; end
            OP_PROG_SEC2:   begin pattern = 4'b1100; is_prog = 1'b1; end
            OP_PROG_SEC3:   begin pattern = 4'b0101; is_prog = 1'b1; end
            OP_PROG_CLK6:   begin pattern = 4'b0010; is_prog = 1'b1; end
            OP_VERIFY_CLK:  begin pattern = 4'b0110; kind = CAP_CLK;  end
            OP_VERIFY_SEC:  begin pattern = 4'b0100; kind = CAP_SEC;  end
            default:        valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/eprom_seq_capture.sv
module eprom_seq_capture
    import eprom_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  cap_kind_e         kind,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] cap_data,
    output logic [2:0]        sec_bits,
    output logic              clk12_mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data   <= '0;
            sec_bits   <= '0;
            clk12_mode <= 1'b0;
        end else if (sample) begin
            unique case (kind)
                CAP_BYTE: cap_data   <= data_in;
                CAP_SEC:  sec_bits   <= {data_in[3], data_in[6], data_in[7]};
                CAP_CLK:  clk12_mode <= data_in[4];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/eprom_burst_sequencer.sv
module eprom_burst_sequencer
    import eprom_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int LOW_US     = 100,
    parameter int HIGH_US    = 10,
    parameter int SETUP_CYC  = 200,
    parameter int SETTLE_CYC = 100,
    parameter int PULSES     = 5,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    output logic [3:0]        mode_sel,
    output logic              tgt_rst,
    output logic              tgt_psen_n,
    output logic              prog_n,
    output logic              vpp_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] cap_data,
    output logic [2:0]        sec_bits,
    output logic              clk12_mode
);
    localparam int LOW_CYC  = CLK_MHZ * LOW_US;
    localparam int HIGH_CYC = CLK_MHZ * HIGH_US;
    localparam int MAX_A    = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int MAX_B    = (SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC;
    localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int PULSE_W  = $clog2(PULSES + 1);

    seq_state_e        state, state_nx;
    logic [3:0]        op_q;
    logic [PULSE_W-1:0] pulse_cnt;
    logic [3:0]        dec_op;
    logic              dec_valid, dec_prog;
    logic [3:0]        dec_pattern;
    cap_kind_e         dec_kind;
    logic [CNT_W-1:0]  tmr_limit;
    logic              tmr_last, tmr_clr;
    logic              last_pulse;

    assign dec_op = (state == S_IDLE) ? op_code : op_q;

    eprom_seq_decode u_dec (
        .op      (dec_op),
        .valid   (dec_valid),
        .is_prog (dec_prog),
        .pattern (dec_pattern),
        .kind    (dec_kind)
    );

    always_comb begin
        unique case (state)
            S_SETUP:     tmr_limit = CNT_W'(SETUP_CYC);
            S_STROBE_LO: tmr_limit = CNT_W'(LOW_CYC);
            S_STROBE_HI: tmr_limit = CNT_W'(HIGH_CYC);
            S_SETTLE:    tmr_limit = CNT_W'(SETTLE_CYC);
            default:     tmr_limit = CNT_W'(1);
        endcase
    end

    assign tmr_clr = (state == S_IDLE) || tmr_last;

    eprom_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    eprom_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .sample     ((state == S_SETTLE) && tmr_last),
        .kind       (dec_kind),
        .data_in    (data_in),
        .cap_data   (cap_data),
        .sec_bits   (sec_bits),
        .clk12_mode (clk12_mode)
    );

    assign last_pulse = (pulse_cnt == PULSE_W'(PULSES - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start && dec_valid) state_nx = dec_prog ? S_SETUP : S_SETTLE;
            S_SETUP:     if (tmr_last) state_nx = S_STROBE_LO;
            S_STROBE_LO: if (tmr_last) state_nx = S_STROBE_HI;
            S_STROBE_HI: if (tmr_last) state_nx = last_pulse ? S_FINISH : S_STROBE_LO;
            S_SETTLE:    if (tmr_last) state_nx = S_FINISH;
            S_FINISH:    state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register with operation latch and strobe counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op_q      <= '0;
            pulse_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE) begin
                op_q      <= op_code;
                pulse_cnt <= '0;
            end else if (state == S_STROBE_HI && tmr_last) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_FINISH);
        tgt_rst    = busy;
        tgt_psen_n = !busy;
        mode_sel   = busy ? dec_pattern : 4'b0000;
        prog_n     = (state != S_STROBE_LO);
        vpp_en     = (state == S_SETUP) || (state == S_STROBE_LO) || (state == S_STROBE_HI);
    end
endmodule

// File: rtl/eprom_seq_checker.sv
module eprom_seq_checker #(
    parameter int LOW_CYC = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       prog_n,
    input logic       vpp_en,
    input logic       busy,
    input logic       done,
    input logic [3:0] mode_sel
);
    int unsigned lo_run;

    always_ff @(posedge clk) begin
        if (rst || prog_n) lo_run <= 0;
        else               lo_run <= lo_run + 1;
    end

    a_r5_strobe_needs_vpp: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> vpp_en);

    a_r3_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_n) |-> (lo_run == LOW_CYC));

    a_r13_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r13_done_when_busy_high_strobe: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && prog_n && !vpp_en));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (prog_n && !vpp_en && !done && mode_sel == 4'b0000));

    a_r11_mode_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_sel));
endmodule

bind eprom_burst_sequencer eprom_seq_checker #(.LOW_CYC(LOW_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .prog_n   (prog_n),
    .vpp_en   (vpp_en),
    .busy     (busy),
    .done     (done),
    .mode_sel (mode_sel)
);

// File: tb/eprom_burst_sequencer_test.sv
module eprom_burst_sequencer_test;
    localparam int S  = 4;
    localparam int L  = 100;
    localparam int H  = 10;
    localparam int ST = 5;
    localparam int NP = 5;

    logic       clk = 0;
    logic       rst = 1;
    logic [3:0] op_code = 0;
    logic       start = 0;
    logic [7:0] data_in = 0;
    logic [3:0] mode_sel;
    logic       tgt_rst, tgt_psen_n, prog_n, vpp_en, busy, done;
    logic [7:0] cap_data;
    logic [2:0] sec_bits;
    logic       clk12_mode;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_cap = 0;
    logic [2:0] exp_sec = 0;
    logic       exp_clk = 0;

    always #2.5 clk = ~clk;

    eprom_burst_sequencer #(
        .CLK_MHZ(1), .LOW_US(L), .HIGH_US(H),
        .SETUP_CYC(S), .SETTLE_CYC(ST), .PULSES(NP)
    ) uut (
        .clk(clk), .rst(rst), .op_code(op_code), .start(start), .data_in(data_in),
        .mode_sel(mode_sel), .tgt_rst(tgt_rst), .tgt_psen_n(tgt_psen_n),
        .prog_n(prog_n), .vpp_en(vpp_en), .busy(busy), .done(done),
        .cap_data(cap_data), .sec_bits(sec_bits), .clk12_mode(clk12_mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] pat(input int op);
        case (op)
            1: return 4'b1011;  2: return 4'b0011;  3: return 4'b1010;
            4: return 4'b1111;  5: return 4'b1100;  6: return 4'b0101;
            7: return 4'b0010;  8: return 4'b0110;  9: return 4'b0100;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic bit prog_op(input int op);
        return op == 1 || (op >= 3 && op <= 7);
    endfunction

    // itf_t: cycle index at which a foreign start is injected (0 = none)
    task automatic run_op(input int op, input logic [7:0] d, input int itf_t, input int itf_op);
        int tend;
        bit valid = (op <= 9);
        bit pg = prog_op(op);
        tend = !valid ? 0 : (pg ? S + NP * (L + H) + 1 : ST + 1);
        @(negedge clk);
        data_in = d;
        op_code = 4'(op);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int t = 1; t <= tend + 3; t++) begin
            bit e_busy = (t <= tend);
            bit e_done = (t == tend);
            bit e_lo = 0;
            bit e_vpp = pg && (t < tend);
            string tp;
            if (pg && t > S && t < tend) begin
                int u = t - S - 1;
                e_lo = (u % (L + H)) < L;
            end
            tp = !valid ? "R12" : (!pg ? "R7" : (t <= S ? "R6" : (e_lo ? "R3" : "R4")));
            check(!valid ? "R12 busy" : "R2 busy", busy, e_busy);
            check(itf_t != 0 ? "R11 done" : "R13 done", done, e_done);
            check({tp, " prog_n"}, prog_n, !e_lo);
            check(pg ? "R5 vpp_en" : {tp, " vpp_en"}, vpp_en, e_vpp);
            check("R2 tgt_rst/psen", {tgt_rst, tgt_psen_n}, {e_busy, !e_busy});
            check(itf_t != 0 ? "R11 mode_sel" : "R1 mode_sel", mode_sel, e_busy ? pat(op) : 4'b0000);
            if (itf_t != 0 && t == itf_t) begin
                op_code = 4'(itf_op);
                start = 1;
            end else begin
                start = 0;
                op_code = 4'(op);
            end
            @(negedge clk);
        end
        if (op == 0 || op == 2) exp_cap = d;
        if (op == 9) exp_sec = {d[3], d[6], d[7]};
        if (op == 8) exp_clk = d[4];
        check("R8 cap_data", cap_data, exp_cap);
        check("R9 sec_bits", sec_bits, exp_sec);
        check("R10 clk12_mode", clk12_mode, exp_clk);
    endtask

    initial begin
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h98, 8'h67};
        repeat (3) @(negedge clk);
        check("R2 reset busy", busy, 0);
        check("R2 reset outputs", {done, prog_n, vpp_en, tgt_rst, tgt_psen_n}, 5'b01001);
        check("R2 reset captures", {cap_data, sec_bits, clk12_mode}, 0);
        rst = 0;
        @(negedge clk);
        for (int op = 0; op < 16; op++)
            for (int p = 0; p < 4; p++)
                run_op(op, pats[p], 0, 0);
        // starts injected while busy: mid-setup, mid-low, mid-high, last high cycle
        run_op(1, 8'h3C, 2, 9);
        run_op(4, 8'hC3, S + L + H + 50, 2);
        run_op(7, 8'h11, S + 2 * (L + H) + L + 3, 8);
        run_op(3, 8'h22, S + NP * (L + H), 1);
        run_op(2, 8'hB6, 3, 5);
        run_op(9, 8'h49, ST, 0);
        run_op(8, 8'h10, 1, 6);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule